// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host processor read and write the on-chip data RAM (16-bit words) and program RAM (24-bit words) over one shared 16-bit address/data bus. The host first places a start address and a memory-select bit on the bus and drops the latch strobe. It then performs any number of read or write phases, each framed by the active-low select strobe together with the active-low read or write strobe. The host strobes are asynchronous to the core. They are registered once into the core clock domain. The access to the RAM takes place in the following core cycle.

The latched address steps forward after every completed word, so a block transfer needs only one latch phase. A program word moves in two bus phases: the upper 16 bits first, then the low 8 bits on bus bits 7:0. A write phase into the protected top region of data memory is discarded. The core can also set the address and memory-select bit itself. When the core and the port want the same RAM in one cycle, the port takes the RAM and the core is told to stall. The RAMs themselves sit outside the block as plain synchronous memories.

Top module: `hostram_port`

## Requirements
- R1: After reset, `h_ack` is 1, `h_ad_out` is 0, the latched address is 0 and the latched target is data memory. A read with no prior latch returns data-memory word 0.
- R2: When `h_al` falls, the bus value seen while `h_al` was still high is latched. Bits 13:0 become the word address. Bit 14 selects the target, with 1 meaning program memory and 0 meaning data memory. Bit 15 is ignored. The program-word half pointer is reset to the upper half.
- R3: One access starts each time the condition (`h_sel_n` low and `h_rd_n` low) or (`h_sel_n` low and `h_wr_n` low) becomes true. A read or write strobe while `h_sel_n` is high starts nothing, leaves `h_ack` high, does not drive `h_ad_oe` and does not move the address.
- R4: Let edge k be the first clock edge that samples a strobe. `h_ack` is low after edge k. For a write, `h_ack` is high again after edge k+1. For a read, `h_ack` is high again after edge k+2, and at that point `h_ad_out` holds the read data.
- R5: A data-memory write stores the 16-bit bus value at the latched address. A data-memory read returns the stored word.
- R6: A program word takes two phases. The first phase carries bits 23:8. The second phase carries bits 7:0 on bus bits 7:0, and a read returns zeros in bus bits 15:8 on that phase. A write reaches the RAM only on the second phase.
- R7: The address increments by one after every data-memory access and after every second program-memory phase. It wraps from 0x3FFF to 0x0000.
- R8: A host write to a data-memory address at or above 0x3FE0 leaves the stored word unchanged, yet the address still increments. Host reads of that region are allowed.
- R9: A `core_ld` pulse loads the address from `core_ld_addr`, loads the target from `core_ld_pm` (1 meaning program memory), and resets the half pointer.
- R10: In a cycle where the port uses a RAM that the core also requests, the port drives that RAM and the matching `core_*_stall` is high for that one cycle. At all other times the core's request passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| h_sel_n | input | 1 | Host select, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_al | input | 1 | Host address latch, latched on its falling edge |
| h_ad_in | input | 16 | Bus value driven by the host |
| h_ad_out | output | 16 | Read data toward the host |
| h_ad_oe | output | 1 | Bus drive enable during a host read |
| h_ack | output | 1 | High when the port can take the next phase |
| core_ld | input | 1 | Core load of address and target |
| core_ld_addr | input | 14 | Address for a core load |
| core_ld_pm | input | 1 | Target for a core load (1 = program memory) |
| core_dm_req | input | 1 | Core data-RAM request |
| core_dm_we | input | 1 | Core data-RAM write enable |
| core_dm_addr | input | 14 | Core data-RAM address |
| core_dm_wdata | input | 16 | Core data-RAM write data |
| core_dm_stall | output | 1 | Core data-RAM request lost this cycle |
| core_pm_req | input | 1 | Core program-RAM request |
| core_pm_we | input | 1 | Core program-RAM write enable |
| core_pm_addr | input | 14 | Core program-RAM address |
| core_pm_wdata | input | 24 | Core program-RAM write data |
| core_pm_stall | output | 1 | Core program-RAM request lost this cycle |
| dm_en | output | 1 | Data RAM enable |
| dm_we | output | 1 | Data RAM write enable |
| dm_addr | output | 14 | Data RAM address |
| dm_wdata | output | 16 | Data RAM write data |
| dm_rdata | input | 16 | Data RAM read data, one cycle after enable |
| pm_en | output | 1 | Program RAM enable |
| pm_we | output | 1 | Program RAM write enable |
| pm_addr | output | 14 | Program RAM address |
| pm_wdata | output | 24 | Program RAM write data |
| pm_rdata | input | 24 | Program RAM read data, one cycle after enable |

## Verification
Two events can fall in the same cycle. The first is a host access reaching a RAM. The second is a core request to that same RAM. The bench holds a core request on data memory, and then on program memory, for the whole length of a host write. It counts the cycles in which the stall output is high: exactly one stall is expected on data memory, no stall on the first program half, and one on the second program half. The bench then reads the written words back through the port, which shows that the port won each of those cycles.

// File: rtl/hostram_port.sv
module hostram_port #(
  parameter int AW = 14,
  parameter int DW = 16,
  parameter int PW = 24,
  parameter int PROT_BASE = 16'h3FE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_sel_n,
  input  logic          h_rd_n,
  input  logic          h_wr_n,
  input  logic          h_al,
  input  logic [DW-1:0] h_ad_in,
  output logic [DW-1:0] h_ad_out,
  output logic          h_ad_oe,
  output logic          h_ack,
  input  logic          core_ld,
  input  logic [AW-1:0] core_ld_addr,
  input  logic          core_ld_pm,
  input  logic          core_dm_req,
  input  logic          core_dm_we,
  input  logic [AW-1:0] core_dm_addr,
  input  logic [DW-1:0] core_dm_wdata,
  output logic          core_dm_stall,
  input  logic          core_pm_req,
  input  logic          core_pm_we,
  input  logic [AW-1:0] core_pm_addr,
  input  logic [PW-1:0] core_pm_wdata,
  output logic          core_pm_stall,
  output logic          dm_en,
  output logic          dm_we,
  output logic [AW-1:0] dm_addr,
  output logic [DW-1:0] dm_wdata,
  input  logic [DW-1:0] dm_rdata,
  output logic          pm_en,
  output logic          pm_we,
  output logic [AW-1:0] pm_addr,
  output logic [PW-1:0] pm_wdata,
  input  logic [PW-1:0] pm_rdata
);

  localparam int LW = PW - DW;
  localparam logic [AW-1:0] PROT_A = PROT_BASE[AW-1:0];
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic          rd_q, rd_p, wr_q, wr_p, al_q, al_p;
  logic [DW-1:0] bus_q;
  logic [AW:0]   bus_p;
  logic [AW-1:0] addr_q;
  logic          pm_q, half_q, rcap_q, rhi_q, rlo_q;
  logic [DW-1:0] hold_q, dout_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q <= 1'b0; rd_p <= 1'b0;
      wr_q <= 1'b0; wr_p <= 1'b0;
      al_q <= 1'b0; al_p <= 1'b0;
      bus_q <= '0;  bus_p <= '0;
    end else begin
      rd_q <= ~h_sel_n & ~h_rd_n;
      wr_q <= ~h_sel_n & ~h_wr_n;
      al_q <= h_al;
      rd_p <= rd_q;
      wr_p <= wr_q;
      al_p <= al_q;
      bus_q <= h_ad_in;
      bus_p <= bus_q[AW:0];
    end

  wire rd_go   = rd_q & ~rd_p;
  wire wr_go   = wr_q & ~wr_p & ~rd_go;
  wire al_fall = al_p & ~al_q;
  wire go      = rd_go | wr_go;
  wire prot    = addr_q >= PROT_A;
  wire step    = go & (~pm_q | half_q);

  wire port_dm = ~pm_q & (rd_go | (wr_go & ~prot));
  wire port_pm = pm_q & ((rd_go & ~half_q) | (wr_go & half_q));

  assign dm_en    = port_dm | core_dm_req;
  assign dm_we    = port_dm ? wr_go  : core_dm_we;
  assign dm_addr  = port_dm ? addr_q : core_dm_addr;
  assign dm_wdata = port_dm ? bus_q  : core_dm_wdata;
  assign pm_en    = port_pm | core_pm_req;
  assign pm_we    = port_pm ? wr_go  : core_pm_we;
  assign pm_addr  = port_pm ? addr_q : core_pm_addr;
  assign pm_wdata = port_pm ? {hold_q, bus_q[LW-1:0]} : core_pm_wdata;

  assign core_dm_stall = core_dm_req & port_dm;
  assign core_pm_stall = core_pm_req & port_pm;

  assign h_ack    = ~(go | al_fall | rcap_q);
  assign h_ad_oe  = ~h_sel_n & ~h_rd_n;
  assign h_ad_out = dout_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      pm_q   <= 1'b0;
      half_q <= 1'b0;
    end else if (al_fall) begin
      addr_q <= bus_p[AW-1:0];
      pm_q   <= bus_p[AW];
      half_q <= 1'b0;
    end else if (core_ld) begin
      addr_q <= core_ld_addr;
      pm_q   <= core_ld_pm;
      half_q <= 1'b0;
    end else begin
      if (step) addr_q <= addr_q + ONE;
      if (go & pm_q) half_q <= ~half_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcap_q <= 1'b0;
      rhi_q  <= 1'b0;
      rlo_q  <= 1'b0;
      hold_q <= '0;
      dout_q <= '0;
    end else begin
      rcap_q <= rd_go;
      rhi_q  <= rd_go & pm_q & ~half_q;
      rlo_q  <= rd_go & pm_q & half_q;
      if (wr_go & pm_q & ~half_q) hold_q <= bus_q;
      if (rcap_q) begin
        if (rhi_q) begin
          dout_q <= pm_rdata[PW-1:LW];
          hold_q[LW-1:0] <= pm_rdata[LW-1:0];
        end else if (rlo_q)
          dout_q <= {{(DW-LW){1'b0}}, hold_q[LW-1:0]};
        else
          dout_q <= dm_rdata;
      end
    end

  a_r4_read_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !h_ack);

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !al_fall && !core_ld) |=> addr_q == $past(addr_q) + ONE);

  a_r6_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && pm_q && !half_q && !al_fall && !core_ld) |=> half_q);

  a_r6_first_half_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && pm_q && !half_q && !core_pm_req) |-> !pm_en);

  a_r8_prot_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !pm_q && prot && !core_dm_req) |-> !dm_en);

  a_r10_dm_core_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (core_dm_req && !core_dm_stall) |-> (dm_addr == core_dm_addr && dm_we == core_dm_we));

  a_r10_pm_core_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pm_req && !core_pm_stall) |-> (pm_addr == core_pm_addr && pm_we == core_pm_we));

endmodule

// File: tb/hostram_port_tb.sv
module hostram_port_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic h_sel_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1, h_al = 1'b0;
  logic [15:0] h_ad_in = '0;
  logic [15:0] h_ad_out;
  logic h_ad_oe, h_ack;
  logic core_ld = 1'b0, core_ld_pm = 1'b0;
  logic [13:0] core_ld_addr = '0;
  logic core_dm_req = 1'b0, core_dm_we = 1'b0;
  logic [13:0] core_dm_addr = '0;
  logic [15:0] core_dm_wdata = '0;
  logic core_dm_stall;
  logic core_pm_req = 1'b0, core_pm_we = 1'b0;
  logic [13:0] core_pm_addr = '0;
  logic [23:0] core_pm_wdata = '0;
  logic core_pm_stall;
  logic dm_en, dm_we, pm_en, pm_we;
  logic [13:0] dm_addr, pm_addr;
  logic [15:0] dm_wdata;
  logic [15:0] dm_rdata = '0;
  logic [23:0] pm_wdata;
  logic [23:0] pm_rdata = '0;

  hostram_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_sel_n(h_sel_n), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_al(h_al),
    .h_ad_in(h_ad_in), .h_ad_out(h_ad_out), .h_ad_oe(h_ad_oe), .h_ack(h_ack),
    .core_ld(core_ld), .core_ld_addr(core_ld_addr), .core_ld_pm(core_ld_pm),
    .core_dm_req(core_dm_req), .core_dm_we(core_dm_we), .core_dm_addr(core_dm_addr),
    .core_dm_wdata(core_dm_wdata), .core_dm_stall(core_dm_stall),
    .core_pm_req(core_pm_req), .core_pm_we(core_pm_we), .core_pm_addr(core_pm_addr),
    .core_pm_wdata(core_pm_wdata), .core_pm_stall(core_pm_stall),
    .dm_en(dm_en), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
    .pm_en(pm_en), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata)
  );

  logic [15:0] dmem [int];
  logic [23:0] pmem [int];
  always @(posedge clk) begin
    if (dm_en) begin
      if (dm_we) dmem[int'(dm_addr)] = dm_wdata;
      else dm_rdata <= dmem.exists(int'(dm_addr)) ? dmem[int'(dm_addr)] : 16'h0;
    end
    if (pm_en) begin
      if (pm_we) pmem[int'(pm_addr)] = pm_wdata;
      else pm_rdata <= pmem.exists(int'(pm_addr)) ? pmem[int'(pm_addr)] : 24'h0;
    end
  end

  int checks = 0, failures = 0;
  int dm_stalls = 0, pm_stalls = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (core_dm_stall) dm_stalls++;
    if (core_pm_stall) pm_stalls++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [13:0] a, input logic pm, input logic b15);
    @(negedge clk);
    h_ad_in = {b15, pm, a};
    h_al = 1'b1;
    wait_n(2);
    h_al = 1'b0;
    h_ad_in = 16'h5A5A;
    wait_n(3);
  endtask

  task automatic hwrite(input logic [15:0] d);
    @(negedge clk);
    h_ad_in = d; h_sel_n = 1'b0; h_wr_n = 1'b0;
    @(negedge clk); chk("R4 write ack low", h_ack, 1'b0);
    @(negedge clk); chk("R4 write ack back", h_ack, 1'b1);
    h_sel_n = 1'b1; h_wr_n = 1'b1;
    wait_n(2);
  endtask

  task automatic hread(output logic [15:0] d);
    @(negedge clk);
    h_sel_n = 1'b0; h_rd_n = 1'b0;
    @(negedge clk); chk("R4 read ack low", h_ack, 1'b0);
    @(negedge clk); chk("R4 read ack still low", h_ack, 1'b0);
    @(negedge clk); chk("R4 read ack back", h_ack, 1'b1);
    d = h_ad_out;
    h_sel_n = 1'b1; h_rd_n = 1'b1;
    wait_n(2);
  endtask

  task automatic core_dm_write(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk);
    core_dm_req = 1'b1; core_dm_we = 1'b1; core_dm_addr = a; core_dm_wdata = d;
    @(negedge clk);
    core_dm_req = 1'b0; core_dm_we = 1'b0;
  endtask

  function automatic logic [15:0] dpat(input int i);
    return 16'hA55A ^ 16'(i * 16'h0123);
  endfunction
  function automatic logic [23:0] ppat(input int i);
    return 24'h13579B + 24'(i * 24'h010203);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 ack after reset", h_ack, 1'b1);
    chk("R1 dout after reset", h_ad_out, 16'h0);
    core_dm_write(14'h0000, 16'h1111);
    hread(r); chk("R1 reset address/type", r, 16'h1111);

    // R5 R7: data memory write/read sweep
    latch(14'h0010, 1'b0, 1'b0);
    for (int i = 0; i < 48; i++) hwrite(dpat(i));
    latch(14'h0010, 1'b0, 1'b0);
    for (int i = 0; i < 48; i++) begin
      hread(r); chk("R5 R7 dm sweep", r, dpat(i));
    end

    // R2: bit 15 ignored
    latch(14'h0013, 1'b0, 1'b1);
    hread(r); chk("R2 bit15 ignored", r, dpat(3));

    // R3: strobe without select does nothing
    latch(14'h0020, 1'b0, 1'b0);
    @(negedge clk); h_rd_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 no select ack", h_ack, 1'b1);
      chk("R3 no select oe", h_ad_oe, 1'b0);
    end
    h_rd_n = 1'b1; h_wr_n = 1'b0; h_ad_in = 16'hDEAD;
    wait_n(4);
    h_wr_n = 1'b1;
    wait_n(2);
    hread(r); chk("R3 address unmoved", r, dpat(16));

    // R6 R7: program memory sweep
    latch(14'h0200, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin
      logic [23:0] w;
      w = ppat(i);
      hwrite(w[23:8]);
      hwrite({8'h00, w[7:0]});
    end
    latch(14'h0200, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin
      logic [23:0] w;
      w = ppat(i);
      hread(r); chk("R6 pm upper half", r, w[23:8]);
      hread(r); chk("R6 pm low half", r, {8'h00, w[7:0]});
    end

    // R8: protected region
    core_dm_write(14'h3FE0, 16'h1234);
    core_dm_write(14'h3FFF, 16'h0BEE);
    latch(14'h3FDF, 1'b0, 1'b0);
    hwrite(16'h4321);
    hwrite(16'hFFFF);
    hwrite(16'hEEEE);
    latch(14'h3FDF, 1'b0, 1'b0);
    hread(r); chk("R8 below region written", r, 16'h4321);
    hread(r); chk("R8 protected unchanged", r, 16'h1234);
    hread(r); chk("R8 address still stepped", r, 16'h0000);

    // R7: wrap
    latch(14'h0000, 1'b0, 1'b0);
    hwrite(16'h7777);
    latch(14'h3FFF, 1'b0, 1'b0);
    hread(r); chk("R7 top word", r, 16'h0BEE);
    hread(r); chk("R7 wrap to zero", r, 16'h7777);

    // R9: core load
    @(negedge clk); core_ld = 1'b1; core_ld_addr = 14'h0040; core_ld_pm = 1'b0;
    @(negedge clk); core_ld = 1'b0;
    hwrite(16'h4242);
    latch(14'h0040, 1'b0, 1'b0);
    hread(r); chk("R9 core load dm", r, 16'h4242);
    @(negedge clk); core_ld = 1'b1; core_ld_addr = 14'h0300; core_ld_pm = 1'b1;
    @(negedge clk); core_ld = 1'b0;
    hwrite(16'hBEEF);
    hwrite(16'h00C3);
    latch(14'h0300, 1'b1, 1'b0);
    hread(r); chk("R9 core load pm hi", r, 16'hBEEF);
    hread(r); chk("R9 core load pm lo", r, 16'h00C3);

    // R10: collision with core
    latch(14'h0050, 1'b0, 1'b0);
    @(negedge clk);
    core_dm_req = 1'b1; core_dm_we = 1'b0; core_dm_addr = 14'h0005;
    dm_stalls = 0; pm_stalls = 0;
    hwrite(16'h6161);
    chk("R10 dm stall count", dm_stalls, 1);
    chk("R10 no pm stall", pm_stalls, 0);
    core_dm_req = 1'b0;
    latch(14'h0400, 1'b1, 1'b0);
    @(negedge clk);
    core_pm_req = 1'b1; core_pm_we = 1'b0; core_pm_addr = 14'h0006;
    pm_stalls = 0;
    hwrite(16'hA1B2);
    chk("R10 first half no stall", pm_stalls, 0);
    hwrite(16'h00C4);
    chk("R10 second half stall", pm_stalls, 1);
    core_pm_req = 1'b0;
    latch(14'h0050, 1'b0, 1'b0);
    hread(r); chk("R10 port won dm", r, 16'h6161);
    latch(14'h0400, 1'b1, 1'b0);
    hread(r); chk("R10 port won pm hi", r, 16'hA1B2);
    hread(r); chk("R10 port won pm lo", r, 16'h00C4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule